// File: doc/BRIEF.md
# USB NRZI Bit Decoder with Stuff-Bit Removal

This block sits behind a USB line framer that already samples the bus in the middle of each bit period. Each cycle it may receive one line symbol (J, K, SE0 or SE1), marked by a valid strobe. A start-of-packet strobe comes with the first K symbol of a packet, and an end-of-packet strobe comes when the framer recognises the end of the packet. Inside a packet, the block turns the J/K symbols into data bits by NRZI rules. A symbol equal to the one before it is a 1. A symbol that differs from the one before it is a 0.

The block counts consecutive decoded ones. When six ones in a row are followed by a zero, that zero was inserted by the transmitter. The block reports it on its own strobe, does not emit it as data, and starts counting again. When a seventh one arrives instead, the block raises an error strobe and ignores the line until the next start of packet. All outputs are registered, one cycle after the symbol that caused them.

Top module: `usb_nrzi_destuff`

## Requirements
- R1: After reset, `bitValid`, `bitData`, `stuffStrobe` and `errStrobe` are all low and the block is outside any packet.
- R2: `symState` encodes J=0, K=1, SE0=2, SE1=3. Symbols that arrive outside a packet, without `sopStrobe`, produce no output.
- R3: The reference symbol is set to J at `sopStrobe`, so the K that comes with the SOP decodes as 0. After that, a J/K symbol equal to the reference decodes as 1 and a differing one decodes as 0. Each accepted J/K symbol becomes the new reference.
- R4: The outputs for a symbol appear in the cycle after the clock edge that takes in that symbol. They are low in any cycle that follows no accepted symbol.
- R5: When the consecutive-ones count equals six, a decoded 0 pulses `stuffStrobe` without `bitValid` and clears the count. A later run of six ones followed by a 0 is stuffed again.
- R6: A decoded 0 that follows fewer than six ones is output as data.
- R7: When the count equals six, a decoded 1 pulses `errStrobe` without `bitValid`. All symbols after it are ignored until the next `sopStrobe`, and a new SOP decodes normally.
- R8: SE0 and SE1 symbols inside a packet produce no output and leave the reference symbol unchanged.
- R9: `eopStrobe` ends the packet and clears the count. A symbol given with `eopStrobe` is ignored, and so are symbols after it until the next `sopStrobe`.
- R10: At most one of `bitValid`, `stuffStrobe` and `errStrobe` is high in any cycle. `bitData` is low whenever `bitValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | A symbol is presented this cycle |
| symState | input | 2 | Line symbol: J=0, K=1, SE0=2, SE1=3 |
| sopStrobe | input | 1 | Start of packet, given with the first K |
| eopStrobe | input | 1 | End of packet |
| bitValid | output | 1 | Decoded data bit valid |
| bitData | output | 1 | Decoded data bit |
| stuffStrobe | output | 1 | A stuffed zero was removed |
| errStrobe | output | 1 | Seven ones in a row; packet aborted |

## Verification
The bench checks that the SOP K decodes as a zero; a design that kept the previous packet's reference would emit a one there. It sends five ones followed by a zero, and two stuffed runs back to back. An off-by-one run limit or a count that is not cleared after a stuffed zero would drop real data or pass a stuff bit through. It sends a seventh one to check the abort, the symbols that follow it, and a fresh SOP afterwards; a design that skipped the abort would keep emitting bits. It places SE0/SE1 inside a packet and gives a symbol together with EOP; a design that updated the reference on SE0, or honoured the symbol given with EOP, would decode the next bit wrongly or emit a stray one.

// File: rtl/usb_nrzi_pkg.sv
package usb_nrzi_pkg;

  typedef enum logic [1:0] {
    LINE_J   = 2'd0,
    LINE_K   = 2'd1,
    LINE_SE0 = 2'd2,
    LINE_SE1 = 2'd3
  } lineSym_t;

  // Strobes from control to datapath, one cycle's decision
  typedef struct packed {
    logic takeSym;   // symbol accepted: update reference
    logic emitData;  // register a data bit
    logic emitStuff; // register a stuff-bit pulse
    logic emitErr;   // register a stuffing-error pulse
  } ctrlStrb_t;

endpackage

// File: rtl/usb_nrzi_ctrl.sv
module usb_nrzi_ctrl
  import usb_nrzi_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic [1:0] symState,
  input  logic       sopStrobe,
  input  logic       eopStrobe,
  input  logic       rawBit,
  output ctrlStrb_t  ctl
);

  localparam int CW = $clog2(STUFF_RUN + 1);
  localparam logic [CW-1:0] RUN_LIMIT = CW'(STUFF_RUN);

  logic          active, actNext;
  logic [CW-1:0] runCnt, cntNext, cntBase;
  logic          isJK, armed, take, atLimit;

  always_comb begin
    isJK    = (symState == LINE_J) || (symState == LINE_K);
    armed   = active || sopStrobe;
    take    = symValid && isJK && armed && !eopStrobe;
    cntBase = sopStrobe ? '0 : runCnt;
    atLimit = (cntBase == RUN_LIMIT);

    ctl           = '0;
    ctl.takeSym   = take;
    cntNext       = runCnt;
    actNext       = active;

    if (eopStrobe) begin
      cntNext = '0;
      actNext = 1'b0;
    end else begin
      if (sopStrobe) begin
        cntNext = '0;
        actNext = 1'b1;
      end
      if (take) begin
        if (rawBit) begin
          if (atLimit) begin
            ctl.emitErr = 1'b1;
            actNext     = 1'b0;
            cntNext     = '0;
          end else begin
            ctl.emitData = 1'b1;
            cntNext      = cntBase + 1'b1;
          end
        end else begin
          if (atLimit) ctl.emitStuff = 1'b1;
          else         ctl.emitData  = 1'b1;
          cntNext = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      runCnt <= '0;
    end else begin
      active <= actNext;
      runCnt <= cntNext;
    end
  end

  // Count never passes the stuffing limit (R5)
  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= RUN_LIMIT);

  // End of packet leaves the block idle with a cleared count (R9)
  assert_eop_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    eopStrobe |=> (runCnt == '0) && !active);

  // An error aborts the packet (R7)
  assert_err_aborts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.emitErr && !sopStrobe) |=> !active);

  // Nothing is decoded outside a packet (R2)
  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !sopStrobe) |-> !(ctl.emitData || ctl.emitStuff || ctl.emitErr));

endmodule

// File: rtl/usb_nrzi_dpath.sv
module usb_nrzi_dpath
  import usb_nrzi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] symState,
  input  logic       sopStrobe,
  input  ctrlStrb_t  ctl,
  output logic       rawBit,
  output logic       bitValid,
  output logic       bitData,
  output logic       stuffStrobe,
  output logic       errStrobe
);

  logic refK;     // reference symbol: 1 = K, 0 = J
  logic symK;
  logic refUse;

  always_comb begin
    symK   = (symState == LINE_K);
    refUse = sopStrobe ? 1'b0 : refK;   // SOP seeds the idle J
    rawBit = (symK == refUse);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refK        <= 1'b0;
      bitValid    <= 1'b0;
      bitData     <= 1'b0;
      stuffStrobe <= 1'b0;
      errStrobe   <= 1'b0;
    end else begin
      if (ctl.takeSym)    refK <= symK;
      else if (sopStrobe) refK <= 1'b0;
      bitValid    <= ctl.emitData;
      bitData     <= ctl.emitData && rawBit;
      stuffStrobe <= ctl.emitStuff;
      errStrobe   <= ctl.emitErr;
    end
  end

  // Outputs are mutually exclusive (R10)
  assert_single_out_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bitValid, stuffStrobe, errStrobe}));

  // Data bit is quiet without its strobe (R10)
  assert_data_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bitValid |-> !bitData);

  // Reference holds when no symbol is taken and no SOP arrives (R8)
  assert_ref_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.takeSym && !sopStrobe) |=> $stable(refK));

endmodule

// File: rtl/usb_nrzi_destuff.sv
module usb_nrzi_destuff
  import usb_nrzi_pkg::*;
#(
  parameter int STUFF_RUN = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic [1:0] symState,
  input  logic       sopStrobe,
  input  logic       eopStrobe,
  output logic       bitValid,
  output logic       bitData,
  output logic       stuffStrobe,
  output logic       errStrobe
);

  ctrlStrb_t ctl;
  logic      rawBit;

  usb_nrzi_ctrl #(.STUFF_RUN(STUFF_RUN)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .symValid  (symValid),
    .symState  (symState),
    .sopStrobe (sopStrobe),
    .eopStrobe (eopStrobe),
    .rawBit    (rawBit),
    .ctl       (ctl)
  );

  usb_nrzi_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .symState    (symState),
    .sopStrobe   (sopStrobe),
    .ctl         (ctl),
    .rawBit      (rawBit),
    .bitValid    (bitValid),
    .bitData     (bitData),
    .stuffStrobe (stuffStrobe),
    .errStrobe   (errStrobe)
  );

  // Any output pulse follows an input symbol by one cycle (R4)
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid || stuffStrobe || errStrobe) |-> $past(symValid));

endmodule

// File: tb/usb_nrzi_destuff_tb.sv
module usb_nrzi_destuff_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic [1:0] symState = 2'd0;
  logic       sopStrobe = 1'b0;
  logic       eopStrobe = 1'b0;
  logic       bitValid, bitData, stuffStrobe, errStrobe;

  int checks = 0;
  int errors = 0;
  logic lineK = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  usb_nrzi_destuff u_dut (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symState(symState),
    .sopStrobe(sopStrobe), .eopStrobe(eopStrobe), .bitValid(bitValid),
    .bitData(bitData), .stuffStrobe(stuffStrobe), .errStrobe(errStrobe)
  );

  task automatic expectOut(input logic ev, eb, es, ee, input string req);
    checks++;
    if ({bitValid, bitData, stuffStrobe, errStrobe} !== {ev, eb, es, ee}) begin
      errors++;
      $display("FAIL %s: got v/d/s/e=%b%b%b%b expected %b%b%b%b", req,
               bitValid, bitData, stuffStrobe, errStrobe, ev, eb, es, ee);
    end
  endtask

  // Drive one cycle on the falling edge, check just after the next rising edge
  task automatic step(input logic [1:0] s, input logic v, sop, eop,
                      input logic ev, eb, es, ee, input string req);
    @(negedge clk);
    symState = s; symValid = v; sopStrobe = sop; eopStrobe = eop;
    @(posedge clk); #1;
    expectOut(ev, eb, es, ee, req);
    @(negedge clk);
    symValid = 1'b0; sopStrobe = 1'b0; eopStrobe = 1'b0;
  endtask

  task automatic sop(input string req);
    lineK = 1'b1;
    step(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, req);  // K -> 0
  endtask

  // Send a logical bit as NRZI; expectation given separately
  task automatic nrzi(input logic b, input logic ev, eb, es, ee, input string req);
    if (!b) lineK = ~lineK;
    step({1'b0, lineK}, 1'b1, 1'b0, 1'b0, ev, eb, es, ee, req);
  endtask

  task automatic eop(input string req);
    step(2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, req);
  endtask

  task automatic testReset();
    expectOut(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    step(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    step(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
  endtask

  task automatic testNrzi();
    logic pat [6] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    sop("R3");
    foreach (pat[i]) nrzi(pat[i], 1'b1, pat[i], 1'b0, 1'b0, "R3");
    // idle cycle: nothing without an accepted symbol
    step(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    nrzi(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
    eop("R9");
  endtask

  task automatic testStuff();
    sop("R5");
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 6; i++) nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
      nrzi(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
    end
    nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    eop("R9");
  endtask

  task automatic testFive();
    sop("R6");
    for (int i = 0; i < 5; i++) nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    nrzi(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    eop("R9");
  endtask

  task automatic testErr();
    sop("R7");
    for (int i = 0; i < 6; i++) nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    nrzi(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7");
    nrzi(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    nrzi(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    sop("R7");
    nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    eop("R9");
  endtask

  task automatic testLineStates();
    sop("R8");
    nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    step(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    step(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8");   // reference still K
    nrzi(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    eop("R9");
  endtask

  task automatic testEop();
    sop("R9");
    for (int i = 0; i < 3; i++) nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    // J/K symbol given together with EOP is ignored
    step({1'b0, ~lineK}, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
    step(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    sop("R9");
    for (int i = 0; i < 6; i++) nrzi(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    nrzi(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    eop("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testNrzi();
    testStuff();
    testFive();
    testErr();
    testLineStates();
    testEop();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule